// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes a 32-bit RISC core with a 16-bit instruction stream into an exception. It also runs the core's start-up sequence. Two sources can request service. One is an external requester that presents a 4-bit priority level on its pins and holds it there. The other is an internal peripheral source that posts a level and an 8-bit vector number, which the block stores as pending. At each instruction boundary the block picks one of the two sources. It compares the winner against the 4-bit mask held in the core's status register. If the winner is above the mask, the block drives the entry sequence itself over a single-outstanding 32-bit memory bus.

The core is seen only through a small status interface. That interface carries a retire pulse, a flag that says the next instruction is a branch delay slot, and the current SR, VBR, R15 and PC values. The block changes core state through a register-file write port. It writes PC, R15, SR and VBR.

States: `S_RST_PC` (reads the word at address 0 and writes it to PC) → `S_RST_SP` (reads the word at address 4 and writes it to R15) → `S_RST_SR` → `S_RST_VBR` → `S_IDLE`. From `S_IDLE`, an accepted request goes to `S_ACK` (acknowledge pulse) → `S_PUSH_SR` → `S_PUSH_PC` → `S_SP_WR` → `S_SR_WR` → `S_VEC_RD` (vector fetch and PC write). From there the block returns to `S_IDLE` if the minimum entry time has passed, and otherwise goes through `S_HOLD` until it has. Each bus state waits in place until `bus_ready` is seen.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset is released, the block reads address 0 and writes that word to PC, then reads address 4 and writes that word to R15, then writes SR = 0x000000F0 and VBR = 0. It makes no bus writes during this sequence. The `rf_sel` encoding is 0 = PC, 1 = R15, 2 = SR, 3 = VBR.
- R2: A request is accepted only when its level is strictly greater than the mask in SR bits 7:4. A request at or below the mask causes no entry, and the request stays pending.
- R3: The external request wins only when its level is strictly greater than the pending internal level. On a tie, or when the external level is lower, the internal request is taken with its own vector.
- R4: For an external request, the vector number is 64 + (level >> 1).
- R5: Entry first writes SR to address R15−4, then writes PC to address R15−8. R15 is then written as R15−8.
- R6: After the pushes, SR is written with bits 7:4 set to the accepted level and every other bit unchanged. PC is then written with the word read from VBR + 4 × vector.
- R7: Requests are sampled only on a retire pulse while `next_is_delay_slot` is low. A retire pulse with the delay-slot flag high starts no entry.
- R8: Taking the internal request clears its pending level to 0. A new internal post in the same cycle as that take survives it. The external level is not stored, so it remains a request for as long as it is presented.
- R9: `ack_valid` is a one-cycle pulse in the first cycle of entry, and `ack_level` carries the accepted level.
- R10: `busy` is high throughout the reset sequence. It is also high from the cycle after acceptance until entry ends. Entry lasts at least 13 cycles, and exactly 13 when the bus has no wait states.
- R11: While `bus_req` is high and `bus_ready` is low, the request, direction, address and write data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_level | input | 4 | External request level (0 = none) |
| int_post | input | 1 | Posts an internal request |
| int_post_level | input | 4 | Level of the posted internal request |
| int_post_vector | input | 8 | Vector number of the posted internal request |
| insn_retire | input | 1 | An instruction retired this cycle |
| next_is_delay_slot | input | 1 | The next instruction is a branch delay slot |
| sr_in | input | 32 | Current status register |
| vbr_in | input | 32 | Current vector base register |
| sp_in | input | 32 | Current R15 |
| pc_in | input | 32 | Return PC to push |
| busy | output | 1 | Core stalled |
| ack_valid | output | 1 | Acknowledge pulse to the requester |
| ack_level | output | 4 | Level being acknowledged |
| rf_we | output | 1 | Register-file write enable |
| rf_sel | output | 2 | Target register: 0 PC, 1 R15, 2 SR, 3 VBR |
| rf_wdata | output | 32 | Register write data |
| bus_req | output | 1 | Bus request valid |
| bus_we | output | 1 | Bus write |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_ready | input | 1 | Bus access completes this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |

## Verification
Two functions can land in the same cycle: the automatic clearing of the pending internal request when it is taken, and a fresh internal post. The bench provokes this by pulsing `int_post` in the very retire cycle that takes an earlier internal request. It then lowers the mask and retires again. The run passes only if the second entry fetches from the new vector at the new level. A second collision, the external and internal sources presenting equal levels in the same retire cycle, is covered by an exhaustive level sweep. In that sweep, each tie must resolve to the internal vector.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [3:0] {
        S_RST_PC,
        S_RST_SP,
        S_RST_SR,
        S_RST_VBR,
        S_IDLE,
        S_ACK,
        S_PUSH_SR,
        S_PUSH_PC,
        S_SP_WR,
        S_SR_WR,
        S_VEC_RD,
        S_HOLD
    } seq_state_e;

    localparam logic [1:0] SEL_PC  = 2'd0;
    localparam logic [1:0] SEL_SP  = 2'd1;
    localparam logic [1:0] SEL_SR  = 2'd2;
    localparam logic [1:0] SEL_VBR = 2'd3;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int LVL_W        = 4,
    parameter int VEC_W        = 8,
    parameter int EXT_VEC_BASE = 64
) (
    input  logic [LVL_W-1:0] ext_level,
    input  logic [LVL_W-1:0] int_level,
    input  logic [VEC_W-1:0] int_vector,
    input  logic [LVL_W-1:0] mask,
    output logic             take,
    output logic             pick_int,
    output logic [LVL_W-1:0] win_level,
    output logic [VEC_W-1:0] win_vector
);
    logic ext_wins;

    always_comb begin
        ext_wins   = ext_level > int_level;
        pick_int   = !ext_wins;
        win_level  = ext_wins ? ext_level : int_level;
        win_vector = ext_wins ? (VEC_W'(EXT_VEC_BASE) + VEC_W'(ext_level >> 1))
                              : int_vector;
        take       = win_level > mask;
    end
endmodule

// File: rtl/entry_timer.sv
module entry_timer #(
    parameter int MIN_CYCLES = 13
) (
    input  logic clk,
    input  logic clr,
    output logic done
);
    localparam int CNT_W = $clog2(MIN_CYCLES) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int LVL_W        = 4,
    parameter int VEC_W        = 8,
    parameter int MASK_LSB     = 4,
    parameter int EXT_VEC_BASE = 64,
    parameter int MIN_ENTRY    = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] ext_level,
    input  logic             int_post,
    input  logic [LVL_W-1:0] int_post_level,
    input  logic [VEC_W-1:0] int_post_vector,
    input  logic             insn_retire,
    input  logic             next_is_delay_slot,
    input  logic [XLEN-1:0]  sr_in,
    input  logic [XLEN-1:0]  vbr_in,
    input  logic [XLEN-1:0]  sp_in,
    input  logic [XLEN-1:0]  pc_in,
    output logic             busy,
    output logic             ack_valid,
    output logic [LVL_W-1:0] ack_level,
    output logic             rf_we,
    output logic [1:0]       rf_sel,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             bus_req,
    output logic             bus_we,
    output logic [XLEN-1:0]  bus_addr,
    output logic [XLEN-1:0]  bus_wdata,
    input  logic             bus_ready,
    input  logic [XLEN-1:0]  bus_rdata
);
    localparam logic [XLEN-1:0] WORD      = XLEN'(4);
    localparam logic [XLEN-1:0] RESET_SR  = XLEN'({LVL_W{1'b1}}) << MASK_LSB;
    localparam int              VOFF_PAD  = XLEN - VEC_W - 2;

    seq_state_e state, state_nx;

    logic [LVL_W-1:0] ipend_lvl;
    logic [VEC_W-1:0] ipend_vec;
    logic [LVL_W-1:0] lvl_q;
    logic [VEC_W-1:0] vec_q;
    logic [XLEN-1:0]  sr_q, sp_q, pc_q, vbr_q;

    logic             arb_take, arb_int;
    logic [LVL_W-1:0] arb_lvl;
    logic [VEC_W-1:0] arb_vec;
    logic             accept;
    logic             tmr_done;
    logic [XLEN-1:0]  sr_new;

    irq_arbiter #(
        .LVL_W(LVL_W), .VEC_W(VEC_W), .EXT_VEC_BASE(EXT_VEC_BASE)
    ) u_arb (
        .ext_level (ext_level),
        .int_level (ipend_lvl),
        .int_vector(ipend_vec),
        .mask      (sr_in[MASK_LSB +: LVL_W]),
        .take      (arb_take),
        .pick_int  (arb_int),
        .win_level (arb_lvl),
        .win_vector(arb_vec)
    );

    entry_timer #(.MIN_CYCLES(MIN_ENTRY)) u_tmr (
        .clk (clk),
        .clr (state == S_IDLE),
        .done(tmr_done)
    );

    assign accept = (state == S_IDLE) && insn_retire && !next_is_delay_slot && arb_take;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_RST_PC;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_RST_PC:  if (bus_ready) state_nx = S_RST_SP;
            S_RST_SP:  if (bus_ready) state_nx = S_RST_SR;
            S_RST_SR:  state_nx = S_RST_VBR;
            S_RST_VBR: state_nx = S_IDLE;
            S_IDLE:    if (accept) state_nx = S_ACK;
            S_ACK:     state_nx = S_PUSH_SR;
            S_PUSH_SR: if (bus_ready) state_nx = S_PUSH_PC;
            S_PUSH_PC: if (bus_ready) state_nx = S_SP_WR;
            S_SP_WR:   state_nx = S_SR_WR;
            S_SR_WR:   state_nx = S_VEC_RD;
            S_VEC_RD:  if (bus_ready) state_nx = tmr_done ? S_IDLE : S_HOLD;
            S_HOLD:    if (tmr_done) state_nx = S_IDLE;
            default:   state_nx = S_RST_PC;
        endcase
    end

    // captured context and internal pending request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipend_lvl <= '0;
            ipend_vec <= '0;
        end else if (int_post) begin
            ipend_lvl <= int_post_level;
            ipend_vec <= int_post_vector;
        end else if (accept && arb_int) begin
            ipend_lvl <= '0;
        end
        if (accept) begin
            lvl_q <= arb_lvl;
            vec_q <= arb_vec;
            sr_q  <= sr_in;
            sp_q  <= sp_in;
            pc_q  <= pc_in;
            vbr_q <= vbr_in;
        end
    end

    // outputs
    always_comb begin
        sr_new = sr_q;
        sr_new[MASK_LSB +: LVL_W] = lvl_q;

        busy      = (state != S_IDLE);
        ack_valid = 1'b0;
        ack_level = lvl_q;
        rf_we     = 1'b0;
        rf_sel    = SEL_PC;
        rf_wdata  = bus_rdata;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            S_RST_PC: begin
                bus_req = 1'b1;
                rf_we   = bus_ready;
            end
            S_RST_SP: begin
                bus_req  = 1'b1;
                bus_addr = WORD;
                rf_we    = bus_ready;
                rf_sel   = SEL_SP;
            end
            S_RST_SR: begin
                rf_we    = 1'b1;
                rf_sel   = SEL_SR;
                rf_wdata = RESET_SR;
            end
            S_RST_VBR: begin
                rf_we    = 1'b1;
                rf_sel   = SEL_VBR;
                rf_wdata = '0;
            end
            S_ACK: ack_valid = 1'b1;
            S_PUSH_SR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = sp_q - WORD;
                bus_wdata = sr_q;
            end
            S_PUSH_PC: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = sp_q - (WORD << 1);
                bus_wdata = pc_q;
            end
            S_SP_WR: begin
                rf_we    = 1'b1;
                rf_sel   = SEL_SP;
                rf_wdata = sp_q - (WORD << 1);
            end
            S_SR_WR: begin
                rf_we    = 1'b1;
                rf_sel   = SEL_SR;
                rf_wdata = sr_new;
            end
            S_VEC_RD: begin
                bus_req  = 1'b1;
                bus_addr = vbr_q + {{VOFF_PAD{1'b0}}, vec_q, 2'b00};
                rf_we    = bus_ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int XLEN     = 32,
    parameter int LVL_W    = 4,
    parameter int MASK_LSB = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [XLEN-1:0]  sr_in,
    input logic             busy,
    input logic             ack_valid,
    input logic [LVL_W-1:0] ack_level,
    input logic             bus_req,
    input logic             bus_we,
    input logic [XLEN-1:0]  bus_addr,
    input logic [XLEN-1:0]  bus_wdata,
    input logic             bus_ready
);
    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);

    p_ack_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> busy);

    p_ack_above_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_level > $past(sr_in[MASK_LSB +: LVL_W])));

    p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we)
                                     && $stable(bus_addr) && $stable(bus_wdata)));

    p_write_in_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> busy);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .XLEN(XLEN), .LVL_W(LVL_W), .MASK_LSB(MASK_LSB)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sr_in    (sr_in),
    .busy     (busy),
    .ack_valid(ack_valid),
    .ack_level(ack_level),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_ready(bus_ready)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [3:0]  ext_level = '0;
    logic        int_post = 1'b0;
    logic [3:0]  int_post_level = '0;
    logic [7:0]  int_post_vector = '0;
    logic        insn_retire = 1'b0;
    logic        next_is_delay_slot = 1'b0;
    logic        busy, ack_valid, rf_we, bus_req, bus_we, bus_ready;
    logic [3:0]  ack_level;
    logic [1:0]  rf_sel;
    logic [31:0] rf_wdata, bus_addr, bus_wdata, bus_rdata;

    logic [31:0] c_pc = 32'hDEAD_BEEF, c_sp = 32'hDEAD_BEEF;
    logic [31:0] c_sr = 32'hDEAD_BEEF, c_vbr = 32'hDEAD_BEEF;
    logic        set_req = 1'b0;
    logic [31:0] set_pc = '0, set_sp = '0, set_sr = '0, set_vbr = '0;
    logic        wait_mode = 1'b0;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return 32'h8000_0000 | (a * 32'd7);
    endfunction

    assign bus_ready = bus_req && (wait_mode ? cyc[0] : 1'b1);
    assign bus_rdata = mem_rd(bus_addr);

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .ext_level(ext_level), .int_post(int_post),
        .int_post_level(int_post_level), .int_post_vector(int_post_vector),
        .insn_retire(insn_retire), .next_is_delay_slot(next_is_delay_slot),
        .sr_in(c_sr), .vbr_in(c_vbr), .sp_in(c_sp), .pc_in(c_pc),
        .busy(busy), .ack_valid(ack_valid), .ack_level(ack_level),
        .rf_we(rf_we), .rf_sel(rf_sel), .rf_wdata(rf_wdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    // core register model
    always @(posedge clk) begin
        if (set_req) begin
            c_pc <= set_pc; c_sp <= set_sp; c_sr <= set_sr; c_vbr <= set_vbr;
        end else if (rf_we) begin
            case (rf_sel)
                2'd0: c_pc  <= rf_wdata;
                2'd1: c_sp  <= rf_wdata;
                2'd2: c_sr  <= rf_wdata;
                default: c_vbr <= rf_wdata;
            endcase
        end
    end

    // activity log
    logic        log_clr = 1'b1;
    logic [31:0] wr_a [4];
    logic [31:0] wr_d [4];
    int          wr_n, ack_n, busy_n;
    logic [3:0]  ack_l;
    always @(posedge clk) begin
        if (log_clr) begin
            wr_n <= 0; ack_n <= 0; busy_n <= 0;
        end else begin
            if (bus_req && bus_ready && bus_we && wr_n < 4) begin
                wr_a[wr_n[1:0]] <= bus_addr;
                wr_d[wr_n[1:0]] <= bus_wdata;
                wr_n <= wr_n + 1;
            end
            if (ack_valid) begin
                ack_n <= ack_n + 1;
                ack_l <= ack_level;
            end
            if (busy) busy_n <= busy_n + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    int pend_l = 0;
    int pend_v = 0;

    task automatic try_entry(input int ext, input bit post, input int plv, input int pvec,
                             input bit ds, input int mask,
                             input bit late, input int llv, input int lvec);
        int ip, iv, lvl, vec, n;
        bit ext_win, take;
        logic [31:0] sr0, pc0;
        ip = post ? plv : pend_l;
        iv = post ? pvec : pend_v;
        ext_win = ext > ip;
        lvl = ext_win ? ext : ip;
        vec = ext_win ? 64 + (ext >> 1) : iv;
        take = !ds && (lvl > mask);
        pend_l = ip; pend_v = iv;
        if (take && !ext_win) pend_l = 0;
        if (late) begin pend_l = llv; pend_v = lvec; end
        sr0 = 32'h0000_0303 | (32'(mask) << 4);
        pc0 = 32'h2000 + 32'(ext * 16 + plv);

        @(negedge clk);
        set_req = 1'b1; set_sr = sr0; set_sp = 32'h1000; set_pc = pc0; set_vbr = 32'h400;
        log_clr = 1'b1;
        ext_level = 4'(ext);
        int_post = post; int_post_level = 4'(plv); int_post_vector = 8'(pvec);
        @(negedge clk);
        set_req = 1'b0; log_clr = 1'b0;
        int_post = late; int_post_level = 4'(llv); int_post_vector = 8'(lvec);
        insn_retire = 1'b1; next_is_delay_slot = ds;
        @(negedge clk);
        insn_retire = 1'b0; next_is_delay_slot = 1'b0; int_post = 1'b0;
        n = 0;
        while (busy && n < 100) begin @(negedge clk); n++; end

        if (take) begin
            chk("R9 ack count", 32'(ack_n), 1);
            chk("R9 ack level R3", {28'd0, ack_l}, 32'(lvl));
            if (wait_mode) chk("R10 min busy", 32'(busy_n >= 13), 1);
            else           chk("R10 busy len", 32'(busy_n), 13);
            chk("R5 write count", 32'(wr_n), 2);
            chk("R5 SR push addr", wr_a[0], 32'h0FFC);
            chk("R5 SR push data", wr_d[0], sr0);
            chk("R5 PC push addr", wr_a[1], 32'h0FF8);
            chk("R5 PC push data", wr_d[1], pc0);
            chk("R5 R15 final", c_sp, 32'h0FF8);
            chk("R6 SR mask", c_sr, (sr0 & ~32'hF0) | (32'(lvl) << 4));
            chk("R6 R4 R3 vector PC", c_pc, mem_rd(32'h400 + 32'(vec) * 4));
        end else begin
            chk("R2 R7 no ack", 32'(ack_n), 0);
            chk("R2 R7 no busy", 32'(busy_n), 0);
            chk("R2 R7 PC kept", c_pc, pc0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 busy in reset", 32'(busy), 1);
        rst_n = 1'b1;
        log_clr = 1'b0;
        @(negedge clk);
        chk("R10 busy reset seq", 32'(busy), 1);
        for (int k = 0; k < 20 && busy; k++) @(negedge clk);
        chk("R1 PC", c_pc, mem_rd(32'h0));
        chk("R1 R15", c_sp, mem_rd(32'h4));
        chk("R1 SR", c_sr, 32'h0000_00F0);
        chk("R1 VBR", c_vbr, 32'h0);
        chk("R1 no writes", 32'(wr_n), 0);
        chk("R10 idle after reset", 32'(busy), 0);

        // R2 R4: external level against every mask
        for (int m = 0; m < 16; m++)
            for (int e = 0; e < 16; e++)
                try_entry(e, 0, 0, 0, 0, m, 0, 0, 0);

        // R3: internal against external, ties included, then drain
        for (int i = 1; i < 16; i++)
            for (int e = 0; e < 16; e++) begin
                try_entry(e, 1, i, 16 + i * 3, 0, 0, 0, 0, 0);
                try_entry(0, 0, 0, 0, 0, 0, 0, 0, 0);
            end

        // R3 internal pending held below mask, then taken
        try_entry(0, 1, 4, 8'h55, 0, 6, 0, 0, 0);
        try_entry(0, 0, 0, 0, 0, 3, 0, 0, 0);

        // R7: delay slot blocks sampling, then taken
        try_entry(7, 0, 0, 0, 1, 0, 0, 0, 0);
        try_entry(7, 0, 0, 0, 0, 0, 0, 0, 0);
        try_entry(0, 1, 5, 8'h22, 1, 0, 0, 0, 0);
        try_entry(0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R8: new post in the same cycle as the internal take
        try_entry(0, 1, 6, 8'h21, 0, 0, 1, 9, 8'h33);
        chk("R8 post survives", 32'(pend_l), 9);
        try_entry(0, 0, 0, 0, 0, 0, 0, 0, 0);
        try_entry(0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8: external level persists after being taken
        try_entry(10, 0, 0, 0, 0, 0, 0, 0, 0);
        try_entry(10, 0, 0, 0, 0, 0, 0, 0, 0);

        // R11 R10: wait-stated bus
        wait_mode = 1'b1;
        try_entry(13, 0, 0, 0, 0, 2, 0, 0, 0);
        try_entry(0, 1, 8, 8'h7E, 0, 1, 0, 0, 0);
        try_entry(3, 1, 2, 8'h10, 0, 0, 0, 0, 0);
        wait_mode = 1'b0;
        ext_level = '0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule